// File: doc/BRIEF.md
# Fieldbus Test-Fixture Register Bank

This block is a small Wishbone-attached register bank that sits beside a fieldbus protocol core on a production test fixture. Software uses it to pulse a one-cycle reset into the protocol core and to configure the transceiver for an external synchronisation pulse: its termination, its direction, its enable and the level it drives. Software can also force the serial transmit line low, which lets the fixture send deliberately corrupted frames.

In the other direction, the bank exposes the line-driver chip's status lines. The watchdog, carrier-detect and transmit-error inputs are read live. A sticky copy of the watchdog alarm is kept, and rising edges of the transmit-error line are counted. The counter can be cleared by a macrocycle strobe, by the core reset or by a line-driver reset. Every asynchronous input passes through a two-flop synchroniser before it is used.

Top module: `fixture_regbank`

## Requirements
- R1: An access is accepted when `wb_cyc_i` and `wb_stb_i` are high and `wb_ack_o` is low. `wb_ack_o` is high for exactly the one cycle after acceptance. Read data is valid on `wb_dat_o` while `wb_ack_o` is high.
- R2: Writing a word with bit 0 set to word offset 0 raises `core_rst_o` for exactly one cycle, starting the cycle after acceptance. Each such write gives a new pulse, and no intermediate write of 0 is needed. A write with bit 0 clear gives no pulse. Offset 0 reads as zero.
- R3: Word offset 1 holds six read/write control bits: termination (bit 0), direction (bit 1, where 1 means output), enable (bit 2), output level (bit 3), pulse-counter clear (bit 8) and pad direction (bit 9). All other bits read 0, and after reset the whole register reads 0.
- R4: `sync_term_o`, `sync_dir_o`, `pulse_cnt_clr_o` and `pad_dir_o` follow bits 0, 1, 8 and 9 of offset 1. `sync_oe_n_o` is the inverse of bit 2.
- R5: `sync_out_o` equals the output-level bit when the direction bit is 1, and is 0 when the direction bit is 0.
- R6: Bit 0 of offset 2 returns `sync_pad_i` after a two-stage synchroniser. The other bits of offset 2 read 0.
- R7: When bit 0 of offset 3 is 1, `line_txd_o` is 0. Otherwise `line_txd_o` equals `core_txd_i`. Bit 0 of offset 3 reads back, and its reset value is 0.
- R8: Offset 4 is read-only. Bit 0 is the synchronised `drv_wdg_n_i`, bit 1 is the watchdog latch, bit 2 is the synchronised `drv_cd_n_i` and bit 3 is the synchronised `drv_txerr_i`. After reset it reads 4'b0101 while the inputs are idle, where idle means the watchdog and carrier-detect lines high and the transmit-error line low.
- R9: The watchdog latch sets when the synchronised watchdog input is low. It stays set until `core_rst_o` or `drv_rst_i` is high, and a clear wins over a set in the same cycle.
- R10: Offset 5 counts rising edges of the synchronised `drv_txerr_i`. The count is zero-extended to 32 bits, and a level held high counts once.
- R11: The transmit-error count saturates at all ones (CNT_W bits) and does not wrap.
- R12: The count clears to zero on `macro_strobe_i`, on `core_rst_o` or on `drv_rst_i`.
- R13: Writes to offsets 2, 4 and 5 are acknowledged and change nothing. Offsets 6 and 7 are acknowledged, read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | ADR_W | Word offset |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Single-cycle acknowledge |
| sync_pad_i | input | 1 | External sync pin (asynchronous) |
| sync_out_o | output | 1 | Level driven onto the sync pad |
| sync_term_o | output | 1 | Termination enable |
| sync_dir_o | output | 1 | Transceiver direction, 1 = output |
| sync_oe_n_o | output | 1 | Active-low transceiver enable |
| pulse_cnt_clr_o | output | 1 | Pulse counter clear |
| pad_dir_o | output | 1 | Logic-side pad direction |
| core_txd_i | input | 1 | Serial transmit data from the core |
| line_txd_o | output | 1 | Transmit data to the line driver |
| drv_wdg_n_i | input | 1 | Line-driver watchdog, active low |
| drv_cd_n_i | input | 1 | Line-driver carrier detect, active low |
| drv_txerr_i | input | 1 | Line-driver transmit error |
| macro_strobe_i | input | 1 | Macrocycle strobe, clears the error count |
| drv_rst_i | input | 1 | Line-driver reset strobe |
| core_rst_o | output | 1 | One-cycle core reset pulse |

## Verification
- **Control register.** The control register is written with all ones, with only the direction bit set, and with only the output-level bit set. Together these show that the reserved bits are masked, that the enable pin is inverted and that the sync level is driven only in output direction.
- **Error counter.** Transmit-error stimulus comes as short pulses, as one long held level and as a burst longer than the counter range. These cases separate edge counting from level counting and saturation from wrap-around.
- **Watchdog latch.** The watchdog is tested with a one-cycle glitch that must stick, a held level that must read low live while latched, and a clear from each of the two reset sources.
- **Bus map.** Writes to read-only and unmapped offsets are read back to show that they were ignored.

// File: rtl/fixture_regbank.sv
module fixture_regbank #(
  parameter int ADR_W = 3,
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             wb_cyc_i,
  input  logic             wb_stb_i,
  input  logic             wb_we_i,
  input  logic [ADR_W-1:0] wb_adr_i,
  input  logic [31:0]      wb_dat_i,
  output logic [31:0]      wb_dat_o,
  output logic             wb_ack_o,
  input  logic             sync_pad_i,
  output logic             sync_out_o,
  output logic             sync_term_o,
  output logic             sync_dir_o,
  output logic             sync_oe_n_o,
  output logic             pulse_cnt_clr_o,
  output logic             pad_dir_o,
  input  logic             core_txd_i,
  output logic             line_txd_o,
  input  logic             drv_wdg_n_i,
  input  logic             drv_cd_n_i,
  input  logic             drv_txerr_i,
  input  logic             macro_strobe_i,
  input  logic             drv_rst_i,
  output logic             core_rst_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [ADR_W-1:0] A_RST = ADR_W'(0), A_CTL = ADR_W'(1), A_RAW = ADR_W'(2),
                               A_COR = ADR_W'(3), A_STA = ADR_W'(4), A_CNT = ADR_W'(5);

  logic acc, wr;
  logic term_q, dir_q, oe_q, lvl_q, pclr_q, pdir_q, corrupt_q;
  logic [1:0] sync_s, wdg_s, cd_s;
  logic [2:0] txe_s;
  logic wdg_latch_q;
  logic [CNT_W-1:0] err_cnt_q;
  logic clr_all;
  logic [31:0] rd_mux;

  assign acc = wb_cyc_i & wb_stb_i & ~wb_ack_o;
  assign wr  = acc & wb_we_i;
  assign clr_all = core_rst_o | drv_rst_i;

  assign sync_term_o     = term_q;
  assign sync_dir_o      = dir_q;
  assign sync_oe_n_o     = ~oe_q;
  assign pulse_cnt_clr_o = pclr_q;
  assign pad_dir_o       = pdir_q;
  assign sync_out_o      = dir_q & lvl_q;
  assign line_txd_o      = core_txd_i & ~corrupt_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      wb_ack_o   <= 1'b0;
      wb_dat_o   <= '0;
      core_rst_o <= 1'b0;
      term_q <= 1'b0; dir_q <= 1'b0; oe_q <= 1'b0; lvl_q <= 1'b0;
      pclr_q <= 1'b0; pdir_q <= 1'b0; corrupt_q <= 1'b0;
    end else begin
      wb_ack_o   <= acc;
      core_rst_o <= wr && wb_adr_i == A_RST && wb_dat_i[0];
      if (acc) wb_dat_o <= rd_mux;
      if (wr && wb_adr_i == A_CTL) begin
        term_q <= wb_dat_i[0]; dir_q  <= wb_dat_i[1];
        oe_q   <= wb_dat_i[2]; lvl_q  <= wb_dat_i[3];
        pclr_q <= wb_dat_i[8]; pdir_q <= wb_dat_i[9];
      end
      if (wr && wb_adr_i == A_COR) corrupt_q <= wb_dat_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_s <= 2'b00;
      wdg_s  <= 2'b11;
      cd_s   <= 2'b11;
      txe_s  <= 3'b000;
    end else begin
      sync_s <= {sync_s[0], sync_pad_i};
      wdg_s  <= {wdg_s[0], drv_wdg_n_i};
      cd_s   <= {cd_s[0], drv_cd_n_i};
      txe_s  <= {txe_s[1:0], drv_txerr_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)          wdg_latch_q <= 1'b0;
    else if (clr_all)      wdg_latch_q <= 1'b0;
    else if (!wdg_s[1])    wdg_latch_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)                                       err_cnt_q <= '0;
    else if (clr_all || macro_strobe_i)                 err_cnt_q <= '0;
    else if (txe_s[1] && !txe_s[2] && err_cnt_q != CNT_MAX) err_cnt_q <= err_cnt_q + 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    case (wb_adr_i)
      A_CTL: rd_mux = {22'd0, pdir_q, pclr_q, 4'd0, lvl_q, oe_q, dir_q, term_q};
      A_RAW: rd_mux = {31'd0, sync_s[1]};
      A_COR: rd_mux = {31'd0, corrupt_q};
      A_STA: rd_mux = {28'd0, txe_s[1], cd_s[1], wdg_latch_q, wdg_s[1]};
      A_CNT: rd_mux = 32'(err_cnt_q);
      default: rd_mux = '0;
    endcase
  end

  assert_ack_single_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    wb_ack_o |=> !wb_ack_o);
  assert_ack_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o);
  assert_rst_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    core_rst_o |=> !core_rst_o);
  assert_latch_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wdg_latch_q && !core_rst_o && !drv_rst_i) |=> wdg_latch_q);
  assert_latch_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (core_rst_o || drv_rst_i) |=> !wdg_latch_q);
  assert_cnt_sat_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (err_cnt_q == CNT_MAX && !clr_all && !macro_strobe_i) |=> err_cnt_q == CNT_MAX);
  assert_cnt_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (macro_strobe_i || core_rst_o || drv_rst_i) |=> err_cnt_q == '0);
  assert_cnt_step_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!macro_strobe_i && !clr_all) |=> (err_cnt_q == $past(err_cnt_q) || err_cnt_q == $past(err_cnt_q) + 1'b1));
endmodule

// File: tb/fixture_regbank_test.sv
module fixture_regbank_test;
  localparam int CW = 4;
  logic clk = 0, rst_n = 0;
  logic cyc = 0, stb = 0, we = 0;
  logic [2:0] adr = 0;
  logic [31:0] dat_i = 0, dat_o;
  logic ack;
  logic sync_pad = 0, sync_out, term, dir, oe_n, pclr, pdir;
  logic core_txd = 0, line_txd;
  logic wdg_n = 1, cd_n = 1, txerr = 0, macro = 0, drst = 0, crst;
  int vectors = 0, miscompares = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  fixture_regbank #(.ADR_W(3), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_n_i(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(dat_i), .wb_dat_o(dat_o), .wb_ack_o(ack),
    .sync_pad_i(sync_pad), .sync_out_o(sync_out), .sync_term_o(term), .sync_dir_o(dir),
    .sync_oe_n_o(oe_n), .pulse_cnt_clr_o(pclr), .pad_dir_o(pdir),
    .core_txd_i(core_txd), .line_txd_o(line_txd), .drv_wdg_n_i(wdg_n), .drv_cd_n_i(cd_n),
    .drv_txerr_i(txerr), .macro_strobe_i(macro), .drv_rst_i(drst), .core_rst_o(crst));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wb_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cyc = 1; stb = 1; we = 1; adr = a; dat_i = d;
    @(negedge clk); cyc = 0; stb = 0; we = 0;
  endtask

  task automatic wb_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cyc = 1; stb = 1; we = 0; adr = a;
    @(negedge clk); d = dat_o; cyc = 0; stb = 0;
  endtask

  task automatic strobe(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0;
  endtask

  task automatic t_reset;
    chk("R1 ack idle after reset", 32'(ack), 0);
    chk("R2 core_rst idle after reset", 32'(crst), 0);
    chk("R4 oe_n after reset", 32'(oe_n), 1);
    wb_rd(1, rv); chk("R3 ctrl reset value", rv, 0);
    wb_rd(3, rv); chk("R7 corrupt reset value", rv, 0);
    wb_rd(4, rv); chk("R8 status idle after reset", rv, 32'h5);
    wb_rd(5, rv); chk("R10 count reset value", rv, 0);
  endtask

  task automatic t_bus;
    @(negedge clk); cyc = 1; stb = 1; we = 0; adr = 1;
    @(negedge clk); chk("R1 ack one cycle after request", 32'(ack), 1);
    @(negedge clk); chk("R1 ack drops after one cycle", 32'(ack), 0);
    cyc = 0; stb = 0;
    wb_wr(6, 32'hFFFF_FFFF);
    chk("R13 unmapped write acked", 32'(ack), 1);
    wb_rd(6, rv); chk("R13 offset 6 reads zero", rv, 0);
    wb_rd(7, rv); chk("R13 offset 7 reads zero", rv, 0);
    wb_wr(4, 32'hFFFF_FFFF); wb_wr(5, 32'hFFFF_FFFF); wb_wr(2, 32'hFFFF_FFFF);
    wb_rd(4, rv); chk("R13 status ignores write", rv, 32'h5);
    wb_rd(5, rv); chk("R13 count ignores write", rv, 0);
    wb_rd(2, rv); chk("R13 raw input ignores write", rv, 0);
    wb_rd(1, rv); chk("R13 ctrl untouched by other writes", rv, 0);
  endtask

  task automatic t_core_rst;
    wb_wr(0, 32'h1); chk("R2 pulse high", 32'(crst), 1);
    @(negedge clk);  chk("R2 pulse one cycle", 32'(crst), 0);
    wb_wr(0, 32'h1); chk("R2 repeat pulse without clearing", 32'(crst), 1);
    @(negedge clk);  chk("R2 repeat pulse ends", 32'(crst), 0);
    wb_wr(0, 32'h0); chk("R2 zero write no pulse", 32'(crst), 0);
    wb_rd(0, rv);    chk("R2 offset 0 reads zero", rv, 0);
  endtask

  task automatic t_sync_ctrl;
    wb_wr(1, 32'hFFFF_FFFF);
    chk("R4 term pin", 32'(term), 1);
    chk("R4 dir pin", 32'(dir), 1);
    chk("R4 oe_n inverted", 32'(oe_n), 0);
    chk("R4 pulse clr pin", 32'(pclr), 1);
    chk("R4 pad dir pin", 32'(pdir), 1);
    chk("R5 output level driven", 32'(sync_out), 1);
    wb_rd(1, rv); chk("R3 ctrl masked readback", rv, 32'h30F);
    wb_wr(1, 32'h2);
    chk("R5 output dir low level", 32'(sync_out), 0);
    chk("R4 oe_n when enable 0", 32'(oe_n), 1);
    wb_wr(1, 32'h8);
    chk("R5 input dir blocks level", 32'(sync_out), 0);
    wb_rd(1, rv); chk("R3 ctrl level only", rv, 32'h8);
    wb_wr(1, 32'h0);
  endtask

  task automatic t_raw_in;
    sync_pad = 1; idle(3);
    wb_rd(2, rv); chk("R6 raw input high", rv, 1);
    sync_pad = 0; idle(3);
    wb_rd(2, rv); chk("R6 raw input low", rv, 0);
  endtask

  task automatic t_corrupt;
    core_txd = 1; #1; chk("R7 pass-through high", 32'(line_txd), 1);
    wb_wr(3, 32'h1); chk("R7 forced low", 32'(line_txd), 0);
    wb_rd(3, rv); chk("R7 corrupt readback", rv, 1);
    core_txd = 0; #1; chk("R7 forced low with data 0", 32'(line_txd), 0);
    wb_wr(3, 32'h0); core_txd = 1; #1; chk("R7 pass-through restored", 32'(line_txd), 1);
    core_txd = 0; #1; chk("R7 pass-through low", 32'(line_txd), 0);
  endtask

  task automatic t_status;
    cd_n = 0; txerr = 1; idle(4);
    wb_rd(4, rv); chk("R8 cd and txerr live", rv, 32'h9);
    cd_n = 1; txerr = 0; idle(4);
    wb_rd(4, rv); chk("R8 lines back idle", rv, 32'h5);
    wb_rd(5, rv); chk("R10 one edge counted", rv, 1);
    strobe(macro); idle(1);
  endtask

  task automatic t_watchdog;
    @(negedge clk); wdg_n = 0; @(negedge clk); wdg_n = 1; idle(4);
    wb_rd(4, rv); chk("R9 glitch latched", rv, 32'h7);
    strobe(drst); idle(2);
    wb_rd(4, rv); chk("R9 cleared by driver reset", rv, 32'h5);
    wdg_n = 0; idle(4);
    wb_rd(4, rv); chk("R8 live low while latched", rv, 32'h6);
    wdg_n = 1; idle(4);
    wb_rd(4, rv); chk("R9 latch holds", rv, 32'h7);
    wb_wr(0, 32'h1); idle(2);
    wb_rd(4, rv); chk("R9 cleared by core reset", rv, 32'h5);
  endtask

  task automatic pulse_err(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); txerr = 1; idle(2); txerr = 0; idle(2);
    end
    idle(3);
  endtask

  task automatic t_counter;
    pulse_err(3);
    wb_rd(5, rv); chk("R10 three edges", rv, 3);
    @(negedge clk); txerr = 1; idle(10); txerr = 0; idle(4);
    wb_rd(5, rv); chk("R10 held level counts once", rv, 4);
    pulse_err(20);
    wb_rd(5, rv); chk("R11 saturates", rv, 32'hF);
    strobe(macro); idle(1);
    wb_rd(5, rv); chk("R12 macro clear", rv, 0);
    pulse_err(2);
    wb_wr(0, 32'h1); idle(2);
    wb_rd(5, rv); chk("R12 core reset clear", rv, 0);
    pulse_err(2);
    strobe(drst); idle(1);
    wb_rd(5, rv); chk("R12 driver reset clear", rv, 0);
  endtask

  initial begin
    #300000000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    t_reset;
    t_bus;
    t_core_rst;
    t_sync_ctrl;
    t_raw_in;
    t_corrupt;
    t_status;
    t_watchdog;
    t_counter;
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule